// File: doc/BRIEF.md
# Collision Jam and Retry Controller

This block supervises one frame's transmit attempts on a shared half-duplex medium. A start pulse opens an attempt. While the line carries frame bits, a counter advances on each bit tick, so the block always knows how many bits the current attempt has put out. When a collision is reported, that count picks the response. A hit during the 64-bit preamble and start delimiter lets that lead-in run to its end before jamming. A hit after the lead-in but inside the slot window cuts the frame at once and starts the jam. A hit beyond the slot window is treated as late.

After the 32-bit all-zero jam, the block either asks an external backoff timer for a delay and later restarts the attempt, or it gives up. It gives up on a late collision, when retries are disabled, or when the attempt budget is spent. Giving up raises a flush strobe. Every outcome ends with a one-cycle completion pulse and a set of sticky status bits. These bits stay readable until the next frame starts.

The backoff request is a valid/ready handshake. `bo_valid` rises once a normal collision's jam ends. It stays high with `bo_attempt` frozen until the cycle in which `bo_ready` is sampled high, and it drops on the following edge. The backoff side may stall for any number of cycles. The block then waits, with the line idle, for a `bo_done` pulse. Jam bits are not back-pressured: they are paced only by `bit_tick`.

Top module: `col_retry_ctrl`

## Requirements
- R1: After reset every output is low. A `tx_start` pulse seen while idle raises `tx_en` on the next cycle and clears all four status bits and the collision count. A `tx_start` seen while an attempt is in progress is ignored.
- R2: If a collision is sampled while fewer than PRE_BITS (64) bits have been counted, `tx_en` stays high until exactly PRE_BITS bits of the attempt have gone out, and the jam follows directly.
- R3: The jam lasts exactly JAM_BITS (32) bit ticks. During it, `jam_on` is high, `jam_dat` is 0 and `tx_en` is low.
- R4: If a collision is sampled with at least PRE_BITS but fewer than SLOT_BITS (512) bits counted, `tx_en` falls on the next edge and `jam_on` rises on that same edge.
- R5: After the jam of a normal collision, `bo_valid` rises and `bo_attempt` carries the number of collisions so far (1 to MAX_TRY-1). Both hold until `bo_ready` is accepted. The line then stays idle until `bo_done`, after which a fresh attempt starts with its bit count at zero.
- R6: A `frame_end` pulse while frame bits are going out ends the frame. `fin` pulses with no flush. `st_one` is set if exactly one collision preceded the frame's end, and `st_more` is set if two or more did.
- R7: If the collision that ends the MAX_TRY-th (16th) attempt is normal, its jam is followed by `fin`, `flush` and `st_rtry`. `st_one` and `st_more` stay clear and no backoff is requested.
- R8: With `retry_off` high, the first normal collision ends the frame after its jam with `fin`, `flush` and `st_rtry` only, and no backoff request.
- R9: A collision sampled with SLOT_BITS or more bits counted is late. It is still jammed, then ends the frame with `fin`, `flush` and `st_late`, without `st_rtry` and without a backoff request.
- R10: A collision input is ignored while idle, while finishing the preamble, during the jam and while waiting for backoff. It does not lengthen the jam, raise the collision count or start any line activity.
- R11: When `collision` and `frame_end` are sampled in the same cycle, the collision wins: the jam starts and no completion is reported.
- R12: Bit counting for the preamble, slot window and jam advances only on cycles with `bit_tick` high. With ticks on every second cycle, the jam lasts 64 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Pulse that opens a new frame |
| bit_tick | input | 1 | One pulse per line bit time |
| collision | input | 1 | Collision reported by the line interface |
| frame_end | input | 1 | Last bit of frame has been sent |
| retry_off | input | 1 | Abandon the frame on its first collision |
| tx_en | output | 1 | Preamble or frame bits are being sent |
| jam_on | output | 1 | Jam pattern is being sent |
| jam_dat | output | 1 | Jam bit value (always 0) |
| bo_valid | output | 1 | Backoff request valid |
| bo_ready | input | 1 | Backoff request accepted |
| bo_attempt | output | TW | Collisions so far for the backoff computation |
| bo_done | input | 1 | Backoff delay has elapsed |
| fin | output | 1 | One-cycle pulse: frame finished |
| flush | output | 1 | One-cycle pulse: drop the frame from the FIFO |
| st_one | output | 1 | Exactly one retry was needed |
| st_more | output | 1 | More than one retry was needed |
| st_rtry | output | 1 | Frame abandoned after collisions |
| st_late | output | 1 | Frame abandoned after a late collision |

## Verification
The bench builds the block with its defaults: a 64-bit lead-in, a 512-bit slot window, a 32-bit jam and 16 attempts. These values are small enough to count each line bit directly. With them, the exact zone edges (collisions sampled with 63, 64, 511 and 512 bits counted) and a full run of sixteen collisions to exhaustion each take only a few hundred to a few thousand cycles. The same run also reaches the backoff stall, overlapping collision and end-of-frame inputs, and gapped bit ticks.

// File: rtl/cjr_pkg.sv
package cjr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_PAD,
    ST_JAM,
    ST_BOREQ,
    ST_BOWAIT
  } cjr_state_e;

  typedef enum logic [1:0] {
    Z_PRE,
    Z_SLOT,
    Z_LATE
  } cjr_zone_e;

endpackage

// File: rtl/cjr_bitcnt.sv
module cjr_bitcnt
  import cjr_pkg::*;
#(
  parameter int PRE_BITS  = 64,
  parameter int SLOT_BITS = 512
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      en,
  input  logic      tick,
  output cjr_zone_e zone,
  output logic      pre_edge
);
  localparam int CW = $clog2(SLOT_BITS + 1);
  localparam logic [CW-1:0] PRE_C  = CW'(PRE_BITS);
  localparam logic [CW-1:0] SLOT_C = CW'(SLOT_BITS);

  logic [CW-1:0] cnt_q;

  // saturates at the slot limit; beyond it only "late" matters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (en && tick && (cnt_q != SLOT_C)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (cnt_q < PRE_C) begin
      zone = Z_PRE;
    end else if (cnt_q < SLOT_C) begin
      zone = Z_SLOT;
    end else begin
      zone = Z_LATE;
    end
  end

  // the tick that completes the lead-in
  assign pre_edge = en && tick && (cnt_q == (PRE_C - 1'b1));

endmodule

// File: rtl/cjr_jamcnt.sv
module cjr_jamcnt #(
  parameter int JAM_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic last
);
  localparam int JW = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
  localparam logic [JW-1:0] LAST_C = JW'(JAM_BITS - 1);

  logic [JW-1:0] jc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      jc_q <= '0;
    end else if (!en) begin
      jc_q <= '0;
    end else if (tick) begin
      jc_q <= jc_q + 1'b1;
    end
  end

  assign last = en && tick && (jc_q == LAST_C);

endmodule

// File: rtl/cjr_tries.sv
module cjr_tries #(
  parameter int MAX_TRY = 16,
  parameter int TW      = $clog2(MAX_TRY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [TW-1:0] cnt,
  output logic          at_limit
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt      = cnt_q;
  // the next collision would be the last allowed attempt's
  assign at_limit = (cnt_q == TW'(MAX_TRY - 1));

endmodule

// File: rtl/col_retry_ctrl.sv
module col_retry_ctrl
  import cjr_pkg::*;
#(
  parameter int PRE_BITS  = 64,
  parameter int SLOT_BITS = 512,
  parameter int JAM_BITS  = 32,
  parameter int MAX_TRY   = 16,
  localparam int TW       = $clog2(MAX_TRY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic          bit_tick,
  input  logic          collision,
  input  logic          frame_end,
  input  logic          retry_off,
  output logic          tx_en,
  output logic          jam_on,
  output logic          jam_dat,
  output logic          bo_valid,
  input  logic          bo_ready,
  output logic [TW-1:0] bo_attempt,
  input  logic          bo_done,
  output logic          fin,
  output logic          flush,
  output logic          st_one,
  output logic          st_more,
  output logic          st_rtry,
  output logic          st_late
);
  localparam logic JAM_PATTERN = 1'b0;

  cjr_state_e    st_q, st_d;
  cjr_zone_e     zone;
  logic          pre_edge, jam_last;
  logic          late_q, late_d;
  logic          cnt_clr, tries_clr, tries_inc;
  logic [TW-1:0] tries;
  logic          at_limit;
  logic          fin_d, flush_d, stat_clr;
  logic          set_one, set_more, set_rtry, set_late;

  cjr_bitcnt #(
    .PRE_BITS (PRE_BITS),
    .SLOT_BITS(SLOT_BITS)
  ) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .en      (tx_en),
    .tick    (bit_tick),
    .zone    (zone),
    .pre_edge(pre_edge)
  );

  cjr_jamcnt #(
    .JAM_BITS(JAM_BITS)
  ) u_jam (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (jam_on),
    .tick (bit_tick),
    .last (jam_last)
  );

  cjr_tries #(
    .MAX_TRY(MAX_TRY),
    .TW     (TW)
  ) u_tries (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tries_clr),
    .inc     (tries_inc),
    .cnt     (tries),
    .at_limit(at_limit)
  );

  assign tx_en      = (st_q == ST_SEND) || (st_q == ST_PAD);
  assign jam_on     = (st_q == ST_JAM);
  assign jam_dat    = JAM_PATTERN;
  assign bo_valid   = (st_q == ST_BOREQ);
  assign bo_attempt = tries;

  always_comb begin
    st_d      = st_q;
    late_d    = late_q;
    cnt_clr   = 1'b0;
    tries_clr = 1'b0;
    tries_inc = 1'b0;
    fin_d     = 1'b0;
    flush_d   = 1'b0;
    stat_clr  = 1'b0;
    set_one   = 1'b0;
    set_more  = 1'b0;
    set_rtry  = 1'b0;
    set_late  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tx_start) begin
          st_d      = ST_SEND;
          cnt_clr   = 1'b1;
          tries_clr = 1'b1;
          stat_clr  = 1'b1;
          late_d    = 1'b0;
        end
      end
      ST_SEND: begin
        if (collision) begin
          unique case (zone)
            Z_PRE: begin
              st_d   = pre_edge ? ST_JAM : ST_PAD;
              late_d = 1'b0;
            end
            Z_SLOT: begin
              st_d   = ST_JAM;
              late_d = 1'b0;
            end
            default: begin
              st_d   = ST_JAM;
              late_d = 1'b1;
            end
          endcase
        end else if (frame_end) begin
          st_d     = ST_IDLE;
          fin_d    = 1'b1;
          set_one  = (tries == TW'(1));
          set_more = (tries > TW'(1));
        end
      end
      ST_PAD: begin
        if (pre_edge) begin
          st_d = ST_JAM;
        end
      end
      ST_JAM: begin
        if (jam_last) begin
          if (late_q) begin
            st_d     = ST_IDLE;
            fin_d    = 1'b1;
            flush_d  = 1'b1;
            set_late = 1'b1;
          end else if (retry_off || at_limit) begin
            st_d     = ST_IDLE;
            fin_d    = 1'b1;
            flush_d  = 1'b1;
            set_rtry = 1'b1;
          end else begin
            st_d      = ST_BOREQ;
            tries_inc = 1'b1;
          end
        end
      end
      ST_BOREQ: begin
        if (bo_ready) begin
          st_d = ST_BOWAIT;
        end
      end
      ST_BOWAIT: begin
        if (bo_done) begin
          st_d    = ST_SEND;
          cnt_clr = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      late_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      late_q <= late_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fin     <= 1'b0;
      flush   <= 1'b0;
      st_one  <= 1'b0;
      st_more <= 1'b0;
      st_rtry <= 1'b0;
      st_late <= 1'b0;
    end else begin
      fin   <= fin_d;
      flush <= flush_d;
      if (stat_clr) begin
        st_one  <= 1'b0;
        st_more <= 1'b0;
        st_rtry <= 1'b0;
        st_late <= 1'b0;
      end else begin
        if (set_one)  st_one  <= 1'b1;
        if (set_more) st_more <= 1'b1;
        if (set_rtry) st_rtry <= 1'b1;
        if (set_late) st_late <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cjr_checker.sv
module cjr_checker #(
  parameter int JAM_BITS = 32,
  parameter int MAX_TRY  = 16,
  parameter int TW       = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_tick,
  input logic          tx_en,
  input logic          jam_on,
  input logic          bo_valid,
  input logic          bo_ready,
  input logic [TW-1:0] bo_attempt,
  input logic          fin,
  input logic          flush,
  input logic          st_one,
  input logic          st_more,
  input logic          st_rtry,
  input logic          st_late
);
  localparam int JCW = $clog2(JAM_BITS + 1) + 1;

  logic [JCW-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
    end else if (!jam_on) begin
      seen <= '0;
    end else if (bit_tick) begin
      seen <= seen + 1'b1;
    end
  end

  p_jam_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jam_on) |-> (seen == JCW'(JAM_BITS)));

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(jam_on && tx_en));

  p_bo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_valid && !bo_ready) |=> (bo_valid && $stable(bo_attempt)));

  p_bo_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bo_valid |-> ((bo_attempt != '0) && (bo_attempt < TW'(MAX_TRY))));

  p_fin_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (!tx_en && !jam_on && !bo_valid));

  p_flush_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (fin && !st_one && !st_more));

  p_rtry_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_rtry |-> (!st_one && !st_more && !st_late));

  p_late_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_late) |-> flush);

endmodule

bind col_retry_ctrl cjr_checker #(
  .JAM_BITS(JAM_BITS),
  .MAX_TRY (MAX_TRY),
  .TW      (TW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .tx_en     (tx_en),
  .jam_on    (jam_on),
  .bo_valid  (bo_valid),
  .bo_ready  (bo_ready),
  .bo_attempt(bo_attempt),
  .fin       (fin),
  .flush     (flush),
  .st_one    (st_one),
  .st_more   (st_more),
  .st_rtry   (st_rtry),
  .st_late   (st_late)
);

// File: tb/sim_col_retry_ctrl.sv
module sim_col_retry_ctrl;
  localparam int TW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tx_start, bit_tick, collision, frame_end, retry_off;
  logic bo_ready, bo_done;
  logic tx_en, jam_on, jam_dat, bo_valid, fin, flush;
  logic st_one, st_more, st_rtry, st_late;
  logic [TW-1:0] bo_attempt;

  int nchk = 0;
  int nbad = 0;

  col_retry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .bit_tick(bit_tick),
    .collision(collision), .frame_end(frame_end), .retry_off(retry_off),
    .tx_en(tx_en), .jam_on(jam_on), .jam_dat(jam_dat),
    .bo_valid(bo_valid), .bo_ready(bo_ready), .bo_attempt(bo_attempt),
    .bo_done(bo_done), .fin(fin), .flush(flush), .st_one(st_one),
    .st_more(st_more), .st_rtry(st_rtry), .st_late(st_late)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start;
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  // counts line bits until a collision at bit n, then counts jam cycles
  task automatic run_coll(input int n, input int ts_at, input int fe_at,
                          input bit cx_jam, input bit gap,
                          output int bits, output int jams, output int jbad);
    bits = 0; jams = 0; jbad = 0;
    while (tx_en) begin
      bits++;
      collision = (bits == n);
      tx_start  = (bits == ts_at);
      frame_end = (bits == fe_at);
      if (gap) bit_tick = ~bit_tick;
      @(negedge clk);
    end
    collision = 1'b0; tx_start = 1'b0; frame_end = 1'b0;
    while (jam_on) begin
      jams++;
      if (jam_dat !== 1'b0) jbad++;
      collision = cx_jam && (jams == 5);
      if (gap) bit_tick = ~bit_tick;
      @(negedge clk);
    end
    collision = 1'b0;
    bit_tick  = 1'b1;
  endtask

  task automatic run_ok(input int len, output int bits);
    bits = 0;
    while (tx_en) begin
      bits++;
      frame_end = (bits == len);
      @(negedge clk);
    end
    frame_end = 1'b0;
  endtask

  task automatic serve_bo(input int exp, input int hold, input bit cx_wait);
    chk("R5 bo_valid after jam", bo_valid, 1);
    chk("R5 bo_attempt", bo_attempt, exp);
    if (hold > 0) begin
      bo_ready = 1'b0;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk("R5 valid held under stall", bo_valid, 1);
        chk("R5 attempt stable under stall", bo_attempt, exp);
      end
      bo_ready = 1'b1;
    end
    @(negedge clk);
    chk("R5 valid drops after accept", bo_valid, 0);
    if (cx_wait) begin
      collision = 1'b1;
      @(negedge clk);
      collision = 1'b0;
      chk("R10 no line activity in wait", tx_en, 0);
      chk("R10 no jam in wait", jam_on, 0);
    end
    repeat (2) @(negedge clk);
    chk("R5 idle until done", tx_en, 0);
    bo_done = 1'b1;
    @(negedge clk);
    bo_done = 1'b0;
    chk("R5 restart after done", tx_en, 1);
  endtask

  task automatic t_reset;
    chk("R1 reset tx_en", tx_en, 0);
    chk("R1 reset jam_on", jam_on, 0);
    chk("R1 reset bo_valid", bo_valid, 0);
    chk("R1 reset status", {fin, flush, st_one, st_more, st_rtry, st_late}, 0);
    collision = 1'b1;
    repeat (2) @(negedge clk);
    collision = 1'b0;
    chk("R10 idle collision no tx", tx_en, 0);
    chk("R10 idle collision no jam", jam_on, 0);
  endtask

  task automatic t_clean;
    int b;
    do_start();
    run_ok(200, b);
    chk("R6 clean bits", b, 200);
    chk("R6 clean fin", fin, 1);
    chk("R6 clean no flush", flush, 0);
    chk("R6 clean one/more", {st_one, st_more}, 0);
  endtask

  task automatic t_pre;
    int b, j, x;
    do_start();
    run_coll(10, 0, 0, 1'b0, 1'b0, b, j, x);
    chk("R2 preamble finished", b, 64);
    chk("R3 jam length", j, 32);
    chk("R3 jam data zero", x, 0);
    chk("R2 no fin", fin, 0);
    serve_bo(1, 0, 1'b0);
    run_ok(100, b);
    chk("R6 one retry fin", fin, 1);
    chk("R6 one set", st_one, 1);
    chk("R6 more clear", st_more, 0);
  endtask

  task automatic t_bound;
    int b, j, x;
    do_start();
    run_coll(64, 0, 0, 1'b0, 1'b0, b, j, x);
    chk("R2 collision at 63 counted", b, 64);
    serve_bo(1, 0, 1'b0);
    run_coll(65, 0, 0, 1'b0, 1'b0, b, j, x);
    chk("R4 collision at 64 counted", b, 65);
    chk("R4 jam at once", j, 32);
    serve_bo(2, 0, 1'b0);
    run_ok(80, b);
    chk("R6 more set", st_more, 1);
    chk("R6 one clear", st_one, 0);
  endtask

  task automatic t_mid;
    int b, j, x;
    do_start();
    run_coll(300, 0, 0, 1'b0, 1'b0, b, j, x);
    chk("R4 mid cut", b, 300);
    chk("R3 mid jam", j, 32);
    serve_bo(1, 3, 1'b0);
    run_coll(512, 0, 0, 1'b0, 1'b0, b, j, x);
    chk("R4 collision at 511 counted", b, 512);
    chk("R9 511 not late", st_late, 0);
    serve_bo(2, 0, 1'b0);
    run_ok(90, b);
    chk("R6 more after two", st_more, 1);
  endtask

  task automatic t_late;
    int b, j, x;
    do_start();
    run_coll(513, 0, 0, 1'b0, 1'b0, b, j, x);
    chk("R9 late cut", b, 513);
    chk("R9 late jam", j, 32);
    chk("R9 late fin/flush", {fin, flush}, 3);
    chk("R9 late bit", st_late, 1);
    chk("R9 no rtry", st_rtry, 0);
    chk("R9 no backoff", bo_valid, 0);
    @(negedge clk);
    chk("R9 fin is a pulse", fin, 0);
    chk("R9 late sticky", st_late, 1);
  endtask

  task automatic t_exhaust;
    int b, j, x;
    do_start();
    for (int i = 1; i < 16; i++) begin
      run_coll(100, 0, 0, 1'b0, 1'b0, b, j, x);
      serve_bo(i, 0, 1'b0);
    end
    run_coll(100, 0, 0, 1'b0, 1'b0, b, j, x);
    chk("R7 exhausted fin/flush", {fin, flush}, 3);
    chk("R7 rtry set", st_rtry, 1);
    chk("R7 one/more clear", {st_one, st_more}, 0);
    chk("R7 no backoff", bo_valid, 0);
    do_start();
    chk("R1 new start clears rtry", st_rtry, 0);
    run_coll(100, 0, 0, 1'b0, 1'b0, b, j, x);
    serve_bo(1, 0, 1'b0);
    run_ok(70, b);
    chk("R1 count restarted", st_one, 1);
  endtask

  task automatic t_noretry;
    int b, j, x;
    retry_off = 1'b1;
    do_start();
    run_coll(100, 0, 0, 1'b0, 1'b0, b, j, x);
    chk("R8 jam still sent", j, 32);
    chk("R8 fin/flush", {fin, flush}, 3);
    chk("R8 only rtry", {st_one, st_more, st_rtry, st_late}, 2);
    chk("R8 no backoff", bo_valid, 0);
    retry_off = 1'b0;
  endtask

  task automatic t_busy;
    int b, j, x;
    do_start();
    run_coll(50, 30, 0, 1'b0, 1'b0, b, j, x);
    chk("R1 start while busy ignored", b, 64);
    serve_bo(1, 0, 1'b0);
    run_ok(70, b);
    chk("R1 busy frame ends", fin, 1);
  endtask

  task automatic t_ignore;
    int b, j, x;
    do_start();
    run_coll(100, 0, 0, 1'b1, 1'b0, b, j, x);
    chk("R10 jam not extended", j, 32);
    serve_bo(1, 0, 1'b1);
    run_ok(120, b);
    chk("R10 count not raised", {st_one, st_more}, 2);
  endtask

  task automatic t_tie;
    int b, j, x;
    do_start();
    run_coll(100, 0, 100, 1'b0, 1'b0, b, j, x);
    chk("R11 cut at tie", b, 100);
    chk("R11 jam at tie", j, 32);
    chk("R11 no completion", fin, 0);
    serve_bo(1, 0, 1'b0);
    run_ok(75, b);
    chk("R11 frame resent", st_one, 1);
  endtask

  task automatic t_gap;
    int b, j, x;
    do_start();
    run_coll(10, 0, 0, 1'b0, 1'b1, b, j, x);
    chk("R12 gapped jam cycles", j, 64);
    chk("R12 gapped lead-in cycles", int'(b == 127 || b == 128), 1);
    serve_bo(1, 0, 1'b0);
    run_ok(60, b);
    chk("R12 gapped frame ends", fin, 1);
  endtask

  initial begin
    rst_n = 1'b0; tx_start = 1'b0; bit_tick = 1'b1; collision = 1'b0;
    frame_end = 1'b0; retry_off = 1'b0; bo_ready = 1'b1; bo_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_pre();
    t_bound();
    t_mid();
    t_late();
    t_exhaust();
    t_noretry();
    t_busy();
    t_ignore();
    t_tie();
    t_gap();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule